// File: doc/BRIEF.md
# Hibernate Power and Wakeup Controller

This block sits in the always-on domain of a chip, clocked by the 32768 Hz slow clock, and owns the enable of the main supply. Software turns the main supply off by setting a power-down bit. From then on, the register file is write-protected and the pin and watchdog resets have no effect. An enabled wake source then ends hibernation by issuing a hibernate reset of programmable length. The wake sources are a debounced active-low wakeup pin and the alarm event from the time block. Power-down clears when that reset ends, and the supply comes back.

Status bits record which source woke the chip and whether a pin reset or a hibernate reset happened. A stretched power-on reset initialises everything. The register port is a plain synchronous write port plus a combinational read mux. Both the filter time and the reset time are counted in units of 32 slow-clock cycles, so each field value sits at bit 5 and up and reads as a cycle count.

Top module: `hib_power_ctrl`

## Requirements
- R1: `supply_on` is 1 while power-down (bit 0 of the control register, address 0) is 0. Writing 1 to that bit drops `supply_on` to 0 after the next clock edge. `supply_on` returns to 1 only when a hibernate reset ends.
- R2: While power-down is set, `write_protect` is 1 and every register write has no effect.
- R3: When power-down is clear, `wdt_rst` returns the filter, reset-length, wake-enable and status registers to their reset values, and a low `pin_rst_n` sets status bit 4. While power-down is set, both inputs are ignored.
- R4: `wake_pin_n` passes a two-flop synchroniser. It becomes a wake event only after it has been seen low for F×32 consecutive cycles, where F is the filter register field in bits 15:5 at address 1. Any high sample restarts the count. F=1 gives the event on the 35th edge after the pin falls, counting the first sampling edge as 1. F=0 gives it on the 3rd edge.
- R5: A pin event counts only if wake-enable bit 1 (address 3) is set. An alarm event counts only if wake-enable bit 0 is set. Both count only while power-down is set and no hibernate reset is running. An accepted alarm starts the reset at the same edge that samples `alarm_evt`.
- R6: `hib_rst` stays high for R×32 cycles, where R is the reset-length field in bits 11:5 at address 2. R=0 gives 1 cycle. Power-down clears at the edge that ends the reset.
- R7: Status register (address 4): bit 5 is the hibernate-reset flag, bit 4 the pin-reset flag, bit 1 the pin wake and bit 0 the alarm wake. Hardware sets bit 5 and the matching wake bit when a wake is accepted. A written 0 clears a bit and a written 1 leaves it unchanged.
- R8: After `por_n` releases, `por_rst` stays high for POR_CYCLES edges (default 1966, about 60 ms). The reset values are: power-down 0, filter 0x0800, reset-length 0x0FE0, wake-enable 0 and status 0.
- R9: Reads return only the implemented field bits, and unused addresses read 0. After writing 0xFFFF, the filter register reads 0xFFE0, the reset-length register reads 0x0FE0 and the wake-enable register reads 0x0003.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz always-on clock |
| por_n | input | 1 | Raw power-on reset, active low, asynchronous |
| pin_rst_n | input | 1 | Reset-key reset, active low, synchronous |
| wdt_rst | input | 1 | Watchdog reset, active high, synchronous |
| wake_pin_n | input | 1 | Raw wakeup pin, active low, asynchronous |
| alarm_evt | input | 1 | Alarm event from the time block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register select |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read register select |
| rd_data | output | 16 | Read data (combinational) |
| supply_on | output | 1 | 1: pad drives the supply enable low (supply on); 0: pad released |
| hib_rst | output | 1 | Hibernate reset to the main domain |
| por_rst | output | 1 | Stretched power-on reset |
| write_protect | output | 1 | Always-on register writes blocked |

## Verification
Faults in the filter counter show up at the ports as a shift in the edge on which `hib_rst` rises, relative to the falling pin. So the bench counts edges to the exact cycle for F=1 and F=0, and checks that a short glitch raises no reset at all. A faulty length counter shows up as a `hib_rst` pulse of the wrong length, measured at R=0, R=1 and R=2. A stuck power-down bit shows up as `supply_on` failing to return on the same edge. Leaky gating while powered down appears later, through reads of the wake-enable and status registers after the wake.

// File: rtl/hib_pkg.sv
package hib_pkg;
   localparam int DATA_W    = 16;
   localparam int ADDR_W    = 3;
   localparam int UNIT_LOG2 = 5;

   typedef enum logic [ADDR_W-1:0] {
      SEL_CTRL = 3'd0,
      SEL_FILT = 3'd1,
      SEL_RLEN = 3'd2,
      SEL_WEN  = 3'd3,
      SEL_STAT = 3'd4
   } reg_sel_e;

   localparam int ST_ALM = 0;
   localparam int ST_PIN = 1;
   localparam int ST_PPR = 4;
   localparam int ST_HR  = 5;

   localparam int WEN_ALM = 0;
   localparam int WEN_PIN = 1;
endpackage

// File: rtl/hib_por_stretch.sv
module hib_por_stretch #(
   parameter int POR_CYCLES = 1966
) (
   input  logic clk,
   input  logic por_n,
   output logic busy
);
   localparam int CW = (POR_CYCLES < 2) ? 1 : $clog2(POR_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);

   if (POR_CYCLES < 1) begin : g_bad_len
      $error("POR_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= '0;
         busy  <= 1'b1;
      end else if (busy) begin
         if (cnt_q == LAST) busy <= 1'b0;
         else               cnt_q <= cnt_q + 1'b1;
      end
   end

   assert_por_hold_R8: assert property (@(posedge clk) disable iff (!por_n)
      (busy && cnt_q != LAST) |=> busy);
endmodule

// File: rtl/hib_wake_filter.sv
module hib_wake_filter #(
   parameter int FILT_W      = 11,
   parameter int UNIT_LOG2   = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              clr,
   input  logic              pin_n,
   input  logic [FILT_W-1:0] filt,
   output logic              wake
);
   localparam int CNT_W = FILT_W + UNIT_LOG2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CNT_W-1:0]       cnt_q;
   logic [CNT_W-1:0]       target;
   logic                   pin_low;

   assign target  = {filt, {UNIT_LOG2{1'b0}}};
   assign pin_low = ~sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sync_q <= '1;
         cnt_q  <= '0;
      end else if (clr) begin
         sync_q <= '1;
         cnt_q  <= '0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
         if (!pin_low)            cnt_q <= '0;
         else if (cnt_q < target) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign wake = pin_low && (cnt_q >= target);

   assert_filter_lowlevel_R4: assert property (@(posedge clk) disable iff (!por_n || clr)
      (wake && target != '0) |-> $past(pin_low));
endmodule

// File: rtl/hib_rst_timer.sv
module hib_rst_timer #(
   parameter int RLEN_W    = 7,
   parameter int UNIT_LOG2 = 5
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              clr,
   input  logic              start,
   input  logic [RLEN_W-1:0] rlen,
   output logic              busy,
   output logic              done
);
   localparam int CNT_W = RLEN_W + UNIT_LOG2;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load;

   assign load = (rlen == '0) ? CNT_W'(1) : {rlen, {UNIT_LOG2{1'b0}}};
   assign done = busy && (cnt_q == '0);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (clr) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (busy) begin
         if (cnt_q == '0) busy <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= load - CNT_W'(1);
      end
   end

   assert_hold_continues_R6: assert property (@(posedge clk) disable iff (!por_n || clr)
      (busy && cnt_q != '0) |=> busy);
endmodule

// File: rtl/hib_power_ctrl.sv
module hib_power_ctrl
   import hib_pkg::*;
#(
   parameter int              FILT_W      = 11,
   parameter int              RLEN_W      = 7,
   parameter int              SYNC_STAGES = 2,
   parameter int              POR_CYCLES  = 1966,
   parameter logic [10:0]     FILT_INIT   = 11'd64,
   parameter logic [6:0]      RLEN_INIT   = 7'h7F
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              pin_rst_n,
   input  logic              wdt_rst,
   input  logic              wake_pin_n,
   input  logic              alarm_evt,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              supply_on,
   output logic              hib_rst,
   output logic              por_rst,
   output logic              write_protect
);
   localparam int FILT_MSB = UNIT_LOG2 + FILT_W - 1;
   localparam int RLEN_MSB = UNIT_LOG2 + RLEN_W - 1;

   if (FILT_MSB >= DATA_W) begin : g_bad_filt
      $error("filter field does not fit the data word");
   end
   if (RLEN_MSB >= DATA_W) begin : g_bad_rlen
      $error("reset-length field does not fit the data word");
   end
   if (FILT_W != 11 || RLEN_W != 7) begin : g_bad_init
      $error("init parameters are sized for an 11-bit filter and 7-bit length");
   end

   logic              por_busy;
   logic              pd_q;
   logic [FILT_W-1:0] filt_q;
   logic [RLEN_W-1:0] rlen_q;
   logic [1:0]        wen_q;
   logic [5:0]        stat_q;
   logic [5:0]        stat_d;
   logic              pin_wake;
   logic              tmr_busy;
   logic              tmr_done;
   logic              take_pin;
   logic              take_alm;
   logic              accept;
   logic              wr_ok;
   logic              wdt_ok;

   hib_por_stretch #(.POR_CYCLES(POR_CYCLES)) u_por (
      .clk   (clk),
      .por_n (por_n),
      .busy  (por_busy)
   );

   hib_wake_filter #(
      .FILT_W      (FILT_W),
      .UNIT_LOG2   (UNIT_LOG2),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_filt (
      .clk   (clk),
      .por_n (por_n),
      .clr   (por_busy),
      .pin_n (wake_pin_n),
      .filt  (filt_q),
      .wake  (pin_wake)
   );

   hib_rst_timer #(
      .RLEN_W    (RLEN_W),
      .UNIT_LOG2 (UNIT_LOG2)
   ) u_tmr (
      .clk   (clk),
      .por_n (por_n),
      .clr   (por_busy),
      .start (accept),
      .rlen  (rlen_q),
      .busy  (tmr_busy),
      .done  (tmr_done)
   );

   assign take_pin = pd_q && !tmr_busy && wen_q[WEN_PIN] && pin_wake;
   assign take_alm = pd_q && !tmr_busy && wen_q[WEN_ALM] && alarm_evt;
   assign accept   = take_pin || take_alm;
   assign wdt_ok   = !pd_q && wdt_rst;
   assign wr_ok    = !pd_q && !wdt_rst && wr_en;

   always_comb begin
      stat_d = stat_q;
      if (wdt_ok) begin
         stat_d = '0;
      end else if (wr_ok && wr_addr == SEL_STAT) begin
         stat_d[ST_ALM] = stat_q[ST_ALM] & wr_data[ST_ALM];
         stat_d[ST_PIN] = stat_q[ST_PIN] & wr_data[ST_PIN];
         stat_d[ST_PPR] = stat_q[ST_PPR] & wr_data[ST_PPR];
         stat_d[ST_HR]  = stat_q[ST_HR]  & wr_data[ST_HR];
      end
      if (!pd_q && !pin_rst_n) stat_d[ST_PPR] = 1'b1;
      if (accept)              stat_d[ST_HR]  = 1'b1;
      if (take_pin)            stat_d[ST_PIN] = 1'b1;
      if (take_alm)            stat_d[ST_ALM] = 1'b1;
      stat_d[3:2] = 2'b00;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pd_q   <= 1'b0;
         filt_q <= FILT_INIT;
         rlen_q <= RLEN_INIT;
         wen_q  <= '0;
         stat_q <= '0;
      end else if (por_busy) begin
         pd_q   <= 1'b0;
         filt_q <= FILT_INIT;
         rlen_q <= RLEN_INIT;
         wen_q  <= '0;
         stat_q <= '0;
      end else begin
         stat_q <= stat_d;
         if (tmr_done) begin
            pd_q <= 1'b0;
         end else if (wr_ok && wr_addr == SEL_CTRL) begin
            pd_q <= wr_data[0];
         end
         if (wdt_ok) begin
            filt_q <= FILT_INIT;
            rlen_q <= RLEN_INIT;
            wen_q  <= '0;
         end else if (wr_ok) begin
            case (wr_addr)
               SEL_FILT: filt_q <= wr_data[FILT_MSB:UNIT_LOG2];
               SEL_RLEN: rlen_q <= wr_data[RLEN_MSB:UNIT_LOG2];
               SEL_WEN:  wen_q  <= wr_data[1:0];
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         SEL_CTRL: rd_data[0] = pd_q;
         SEL_FILT: rd_data[FILT_MSB:UNIT_LOG2] = filt_q;
         SEL_RLEN: rd_data[RLEN_MSB:UNIT_LOG2] = rlen_q;
         SEL_WEN:  rd_data[1:0] = wen_q;
         SEL_STAT: rd_data[5:0] = stat_q;
         default:  rd_data = '0;
      endcase
   end

   assign supply_on     = !pd_q;
   assign write_protect = pd_q;
   assign hib_rst       = tmr_busy;
   assign por_rst       = por_busy;

   assert_pd_write_R1: assert property (@(posedge clk) disable iff (!por_n || por_busy)
      (wr_en && wr_addr == SEL_CTRL && wr_data[0] && supply_on && !wdt_rst) |=> !supply_on);
   assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (!por_n || por_busy)
      write_protect |=> ($stable(wen_q) && $stable(filt_q) && $stable(rlen_q)));
   assert_resets_ignored_R3: assert property (@(posedge clk) disable iff (!por_n || por_busy)
      (!supply_on && (wdt_rst || !pin_rst_n)) |=> $stable(stat_q[ST_PPR]));
   assert_wake_only_pd_R5: assert property (@(posedge clk) disable iff (!por_n || por_busy)
      $rose(hib_rst) |-> $past(pd_q));
   assert_supply_back_R6: assert property (@(posedge clk) disable iff (!por_n || por_busy)
      $fell(hib_rst) |-> supply_on);
   assert_hr_flag_R7: assert property (@(posedge clk) disable iff (!por_n || por_busy)
      $rose(hib_rst) |-> stat_q[ST_HR]);
endmodule

// File: tb/hib_power_ctrl_test.sv
module hib_power_ctrl_test;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        pin_rst_n = 1'b1;
   logic        wdt_rst = 1'b0;
   logic        wake_pin_n = 1'b1;
   logic        alarm_evt = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = 3'd0;
   logic [15:0] wr_data = 16'd0;
   logic [2:0]  rd_addr = 3'd0;
   logic [15:0] rd_data;
   logic        supply_on, hib_rst, por_rst, write_protect;

   int total = 0;
   int bad = 0;

   hib_power_ctrl uut (
      .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .wdt_rst(wdt_rst),
      .wake_pin_n(wake_pin_n), .alarm_evt(alarm_evt), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .supply_on(supply_on), .hib_rst(hib_rst), .por_rst(por_rst),
      .write_protect(write_protect)
   );

   always #4 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic cycles_until_high(output int n);
      n = 0;
      while (!hib_rst && n < 5000) begin
         @(posedge clk); #1; n++;
      end
   endtask

   task automatic cycles_while_high(output int n);
      n = 0;
      while (hib_rst && n < 5000) begin
         @(posedge clk); #1; n++;
      end
   endtask

   task automatic t_power_on;
      logic [15:0] d;
      @(negedge clk);
      por_n = 1'b1;
      repeat (1965) @(posedge clk);
      #1 chk("R8 por_rst still high", por_rst, 1);
      @(posedge clk);
      #1 chk("R8 por_rst released", por_rst, 0);
      chk("R1 supply on after reset", supply_on, 1);
      chk("R2 no protect after reset", write_protect, 0);
      chk("R8 hib_rst idle", hib_rst, 0);
      rd(3'd0, d); chk("R8 ctrl reset", d, 16'h0000);
      rd(3'd1, d); chk("R8 filter reset", d, 16'h0800);
      rd(3'd2, d); chk("R8 rlen reset", d, 16'h0FE0);
      rd(3'd3, d); chk("R8 wen reset", d, 16'h0000);
      rd(3'd4, d); chk("R8 status reset", d, 16'h0000);
   endtask

   task automatic t_field_masks;
      logic [15:0] d;
      wr(3'd1, 16'hFFFF); rd(3'd1, d); chk("R9 filter mask", d, 16'hFFE0);
      wr(3'd2, 16'hFFFF); rd(3'd2, d); chk("R9 rlen mask", d, 16'h0FE0);
      wr(3'd3, 16'hFFFF); rd(3'd3, d); chk("R9 wen mask", d, 16'h0003);
      wr(3'd4, 16'hFFFF); rd(3'd4, d); chk("R7 write 1 sets nothing", d, 16'h0000);
      rd(3'd6, d); chk("R9 unused address", d, 16'h0000);
   endtask

   task automatic t_pin_reset_flag;
      logic [15:0] d;
      @(negedge clk); pin_rst_n = 1'b0;
      @(negedge clk); pin_rst_n = 1'b1;
      rd(3'd4, d); chk("R3 pin reset flag", d, 16'h0010);
      wr(3'd4, 16'hFFFF); rd(3'd4, d); chk("R7 write 1 keeps flag", d, 16'h0010);
      wr(3'd4, 16'h0000); rd(3'd4, d); chk("R7 write 0 clears flag", d, 16'h0000);
   endtask

   task automatic t_watchdog;
      logic [15:0] d;
      wr(3'd3, 16'h0003);
      wr(3'd2, 16'h0040);
      @(negedge clk); wdt_rst = 1'b1;
      @(negedge clk); wdt_rst = 1'b0;
      rd(3'd3, d); chk("R3 wdt clears wen", d, 16'h0000);
      rd(3'd2, d); chk("R3 wdt restores rlen", d, 16'h0FE0);
      rd(3'd1, d); chk("R3 wdt restores filter", d, 16'h0800);
   endtask

   task automatic t_pin_wake;
      logic [15:0] d;
      int n;
      bit seen;
      wr(3'd1, 16'h0020);
      wr(3'd2, 16'h0020);
      wr(3'd3, 16'h0002);
      wr(3'd4, 16'h0000);
      @(negedge clk); alarm_evt = 1'b1;
      @(negedge clk); alarm_evt = 1'b0;
      repeat (2) @(posedge clk);
      #1 chk("R5 alarm ignored while powered", hib_rst, 0);
      wr(3'd0, 16'h0001);
      chk("R1 supply released", supply_on, 0);
      chk("R2 protect set", write_protect, 1);
      wr(3'd3, 16'h0000); rd(3'd3, d); chk("R2 write blocked", d, 16'h0002);
      @(negedge clk); pin_rst_n = 1'b0; wdt_rst = 1'b1;
      @(negedge clk); pin_rst_n = 1'b1; wdt_rst = 1'b0;
      rd(3'd4, d); chk("R3 pin reset ignored", d, 16'h0000);
      rd(3'd3, d); chk("R3 wdt ignored", d, 16'h0002);
      @(negedge clk); alarm_evt = 1'b1;
      @(negedge clk); alarm_evt = 1'b0;
      repeat (3) @(posedge clk);
      #1 chk("R5 alarm disabled", hib_rst, 0);
      seen = 0;
      @(negedge clk); wake_pin_n = 1'b0;
      for (int i = 0; i < 20; i++) begin
         @(posedge clk); #1; if (hib_rst) seen = 1;
      end
      @(negedge clk); wake_pin_n = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(posedge clk); #1; if (hib_rst) seen = 1;
      end
      chk("R4 glitch filtered", seen, 0);
      @(negedge clk); wake_pin_n = 1'b0;
      cycles_until_high(n);
      chk("R4 filter edge count F=1", n, 35);
      rd(3'd4, d); chk("R7 pin wake status", d, 16'h0022);
      chk("R1 supply still off during reset", supply_on, 0);
      cycles_while_high(n);
      chk("R6 hold length R=1", n, 32);
      chk("R6 supply back", supply_on, 1);
      chk("R2 protect cleared", write_protect, 0);
      rd(3'd0, d); chk("R6 power-down cleared", d, 16'h0000);
      @(negedge clk); wake_pin_n = 1'b1;
      repeat (4) @(posedge clk);
   endtask

   task automatic t_alarm_wake;
      logic [15:0] d;
      bit seen;
      wr(3'd3, 16'h0001);
      wr(3'd2, 16'h0000);
      wr(3'd4, 16'h0000);
      wr(3'd0, 16'h0001);
      seen = 0;
      @(negedge clk); wake_pin_n = 1'b0;
      for (int i = 0; i < 60; i++) begin
         @(posedge clk); #1; if (hib_rst) seen = 1;
      end
      @(negedge clk); wake_pin_n = 1'b1;
      chk("R5 pin disabled", seen, 0);
      repeat (4) @(posedge clk);
      @(negedge clk); alarm_evt = 1'b1;
      @(posedge clk);
      #1 chk("R5 alarm starts reset", hib_rst, 1);
      rd(3'd4, d); chk("R7 alarm wake status", d, 16'h0021);
      @(negedge clk); alarm_evt = 1'b0;
      @(posedge clk);
      #1 chk("R6 hold length R=0", hib_rst, 0);
      chk("R6 supply back after alarm", supply_on, 1);
   endtask

   task automatic t_zero_filter;
      logic [15:0] d;
      int n;
      wr(3'd1, 16'h0000);
      wr(3'd2, 16'h0040);
      wr(3'd3, 16'h0002);
      wr(3'd4, 16'h0000);
      wr(3'd0, 16'h0001);
      @(negedge clk); wake_pin_n = 1'b0;
      cycles_until_high(n);
      chk("R4 filter edge count F=0", n, 3);
      cycles_while_high(n);
      chk("R6 hold length R=2", n, 64);
      rd(3'd4, d); chk("R7 status after F=0 wake", d, 16'h0022);
      @(negedge clk); wake_pin_n = 1'b1;
   endtask

   initial begin
      #(8 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #20;
      t_power_on();
      t_field_masks();
      t_pin_reset_flag();
      t_watchdog();
      t_pin_wake();
      t_alarm_wake();
      t_zero_filter();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule